// File: doc/BRIEF.md
# Peripheral idle-request handshake controller

This block sits between a system power manager and a peripheral core. When the power manager raises an idle request, the block answers it according to a two-bit idle policy held in a 32-bit configuration register. Under the force policy it acknowledges at once and silences the core's outward lines. Under the never policy it ignores the request. Under the two smart policies it waits until the core is no longer busy. The fourth policy also lets a wake event raise a wakeup line while the block is idle.

While idle, a separate two-bit field selects which of the two clocks, interface and functional, must keep running. Outside idle, both clocks are always requested. The active policy is captured whenever the block is running. A policy rewritten during an idle period therefore applies only after the request has been withdrawn.

Top module: `idle_handshake_ctrl`

## Requirements
- R1: The configuration register resets to 0. A write takes effect on the next clock edge. Bits 4:3 (policy), 9:8 (clock keep) and 2 (wakeup enable) are writable, and all other bits read 0.
- R2: With policy 0 (force), a request seen in run state raises idle_ack_o after one edge. While acknowledged, irq_o, dma_req_o and wakeup_o are held low, even when wakeup enable is set.
- R3: With policy 1 (never), idle_ack_o stays low whatever the request does.
- R4: With policies 2 and 3 (smart), the block first enters a waiting state. It acknowledges only on an edge at which core_busy_i is sampled low with the request still high.
- R5: With policy 2, wakeup_o never rises.
- R6: With policy 3 and wakeup enable set, a wake event sampled while acknowledged raises wakeup_o on the next edge. It stays high until the request is withdrawn.
- R7: When idle_req_i is sampled low, idle_ack_o is low after the next edge and the block is back in run state.
- R8: While acknowledged, keep_iclk_o follows bit 8 and keep_fclk_o follows bit 9 of the register. Otherwise both are high.
- R9: A policy written while acknowledged changes neither the acknowledge nor the gating until after the next return to run state.
- R10: Outside a forced idle period, irq_o and dma_req_o follow core_irq_i and core_dma_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration register contents |
| idle_req_i | input | 1 | Idle request from the power manager |
| idle_ack_o | output | 1 | Idle acknowledge |
| core_busy_i | input | 1 | Core reports internal activity |
| core_irq_i | input | 1 | Interrupt from the core |
| core_dma_i | input | 1 | DMA request from the core |
| wake_evt_i | input | 1 | Wake event from the core |
| irq_o | output | 1 | Gated interrupt |
| dma_req_o | output | 1 | Gated DMA request |
| wakeup_o | output | 1 | Wakeup line |
| keep_iclk_o | output | 1 | Interface clock must run |
| keep_fclk_o | output | 1 | Functional clock must run |

## Verification
The assertions assume that the power manager keeps its request high until it sees the acknowledge or decides to withdraw. They also assume that core_busy_i and wake_evt_i change only between clock edges, so their values at each edge are well defined. The stimulus changes every input at the falling edge and holds it across the next rising edge. It drives the request only high or low for whole cycles, so each transition of the handshake is observed at a known edge. Writes during idle periods stand apart from request changes, which keeps the effect of a deferred policy separate from the effect of a withdrawal.

// File: rtl/idle_hs_pkg.sv
package idle_hs_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned POL_LSB  = 3;
  localparam int unsigned CLK_LSB  = 8;
  localparam int unsigned WKEN_BIT = 2;
  localparam int unsigned N_CLK    = 2;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_IDLE = 2'd2
  } hs_state_e;

  typedef enum logic [1:0] {
    POL_FORCE   = 2'd0,
    POL_NEVER   = 2'd1,
    POL_SMART   = 2'd2,
    POL_SMART_W = 2'd3
  } idle_pol_e;
endpackage

// File: rtl/idle_cfg_reg.sv
module idle_cfg_reg
  import idle_hs_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [1:0]       pol_o,
  output logic [N_CLK-1:0] clk_keep_o,
  output logic             wken_o
);
  localparam logic [DW-1:0] WR_MASK = (DW'(3) << POL_LSB) |
                                      (DW'((1 << N_CLK) - 1) << CLK_LSB) |
                                      (DW'(1) << WKEN_BIT);

  logic [DW-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= '0;
    else if (we_i) reg_q <= wdata_i & WR_MASK;
  end

  assign rdata_o    = reg_q;
  assign pol_o      = reg_q[POL_LSB +: 2];
  assign clk_keep_o = reg_q[CLK_LSB +: N_CLK];
  assign wken_o     = reg_q[WKEN_BIT];
endmodule

// File: rtl/idle_hs_fsm.sv
module idle_hs_fsm
  import idle_hs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      busy_i,
  input  logic [1:0] pol_cfg_i,
  output hs_state_e state_o,
  output idle_pol_e pol_o
);
  hs_state_e state_q, state_d;
  idle_pol_e pol_q, pol;

  // policy follows the register only while running
  always_comb pol = (state_q == ST_RUN) ? idle_pol_e'(pol_cfg_i) : pol_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: if (req_i) begin
        unique case (pol)
          POL_FORCE: state_d = ST_IDLE;
          POL_NEVER: state_d = ST_RUN;
          default:   state_d = ST_WAIT;
        endcase
      end
      ST_WAIT: begin
        if (!req_i)       state_d = ST_RUN;
        else if (!busy_i) state_d = ST_IDLE;
      end
      ST_IDLE: if (!req_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      pol_q   <= POL_FORCE;
    end else begin
      state_q <= state_d;
      pol_q   <= pol;
    end
  end

  assign state_o = state_q;
  assign pol_o   = pol;
endmodule

// File: rtl/idle_out_gate.sv
module idle_out_gate
  import idle_hs_pkg::*;
#(
  parameter int unsigned IRQ_W = 1,
  parameter int unsigned DMA_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  hs_state_e        state_i,
  input  idle_pol_e        pol_i,
  input  logic             req_i,
  input  logic             wken_i,
  input  logic [N_CLK-1:0] clk_keep_i,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic [DMA_W-1:0] dma_i,
  input  logic             wake_evt_i,
  output logic [IRQ_W-1:0] irq_o,
  output logic [DMA_W-1:0] dma_o,
  output logic             wakeup_o,
  output logic [N_CLK-1:0] keep_o
);
  logic idle, force_off, wake_q;

  assign idle      = (state_i == ST_IDLE);
  assign force_off = idle && (pol_i == POL_FORCE);

  assign irq_o = force_off ? '0 : irq_i;
  assign dma_o = force_off ? '0 : dma_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wake_q <= 1'b0;
    else if (!req_i)  wake_q <= 1'b0;
    else if (idle && pol_i == POL_SMART_W && wken_i && wake_evt_i)
      wake_q <= 1'b1;
  end

  assign wakeup_o = wake_q;

  for (genvar g = 0; g < N_CLK; g++) begin : g_keep
    assign keep_o[g] = !idle || clk_keep_i[g];
  end
endmodule

// File: rtl/idle_handshake_ctrl.sv
module idle_handshake_ctrl
  import idle_hs_pkg::*;
#(
  parameter int unsigned DW    = REG_W,
  parameter int unsigned IRQ_W = 1,
  parameter int unsigned DMA_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  output logic [DW-1:0]    cfg_rdata_o,
  input  logic             idle_req_i,
  output logic             idle_ack_o,
  input  logic             core_busy_i,
  input  logic [IRQ_W-1:0] core_irq_i,
  input  logic [DMA_W-1:0] core_dma_i,
  input  logic             wake_evt_i,
  output logic [IRQ_W-1:0] irq_o,
  output logic [DMA_W-1:0] dma_req_o,
  output logic             wakeup_o,
  output logic             keep_iclk_o,
  output logic             keep_fclk_o
);
  logic [1:0]       cfg_pol;
  logic [N_CLK-1:0] cfg_keep, keep;
  logic             cfg_wken;
  hs_state_e        state;
  idle_pol_e        act_pol;

  idle_cfg_reg #(.DW(DW)) i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .pol_o      (cfg_pol),
    .clk_keep_o (cfg_keep),
    .wken_o     (cfg_wken)
  );

  idle_hs_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (idle_req_i),
    .busy_i    (core_busy_i),
    .pol_cfg_i (cfg_pol),
    .state_o   (state),
    .pol_o     (act_pol)
  );

  idle_out_gate #(.IRQ_W(IRQ_W), .DMA_W(DMA_W)) i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .pol_i      (act_pol),
    .req_i      (idle_req_i),
    .wken_i     (cfg_wken),
    .clk_keep_i (cfg_keep),
    .irq_i      (core_irq_i),
    .dma_i      (core_dma_i),
    .wake_evt_i (wake_evt_i),
    .irq_o      (irq_o),
    .dma_o      (dma_req_o),
    .wakeup_o   (wakeup_o),
    .keep_o     (keep)
  );

  assign idle_ack_o  = (state == ST_IDLE);
  assign keep_iclk_o = keep[0];
  assign keep_fclk_o = keep[1];
endmodule

// File: rtl/idle_hs_chk.sv
module idle_hs_chk
  import idle_hs_pkg::*;
#(
  parameter int unsigned DW    = REG_W,
  parameter int unsigned IRQ_W = 1,
  parameter int unsigned DMA_W = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [DW-1:0]    cfg_wdata_i,
  input logic [DW-1:0]    cfg_rdata_o,
  input logic             idle_req_i,
  input logic             idle_ack_o,
  input logic             core_busy_i,
  input logic [IRQ_W-1:0] irq_o,
  input logic [DMA_W-1:0] dma_req_o,
  input logic             wakeup_o,
  input logic             keep_iclk_o,
  input logic             keep_fclk_o,
  input logic [1:0]       pol_i
);
  localparam logic [DW-1:0] CHK_MASK = (DW'(3) << POL_LSB) | (DW'(3) << CLK_LSB) |
                                       (DW'(1) << WKEN_BIT);

  // R1
  cfg_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o == ($past(cfg_wdata_i) & CHK_MASK));

  // R2
  force_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ack_o && pol_i == POL_FORCE) |-> (!(|irq_o) && !(|dma_req_o) && !wakeup_o));

  // R3
  never_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_i == POL_NEVER) |-> !idle_ack_o);

  // R4
  smart_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(idle_ack_o) && pol_i[1]) |-> !$past(core_busy_i));

  // R5
  smart_no_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_i == POL_SMART) |-> !wakeup_o);

  // R6
  wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wakeup_o && idle_req_i) |=> wakeup_o);

  // R6
  wake_in_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wakeup_o |-> idle_ack_o);

  // R7
  withdraw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_req_i |=> !idle_ack_o);

  // R8
  keep_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_ack_o |-> (keep_iclk_o && keep_fclk_o));

  // R9
  pol_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ack_o && $past(idle_ack_o)) |-> $stable(pol_i));
endmodule

bind idle_handshake_ctrl idle_hs_chk #(.DW(DW), .IRQ_W(IRQ_W), .DMA_W(DMA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .idle_req_i  (idle_req_i),
  .idle_ack_o  (idle_ack_o),
  .core_busy_i (core_busy_i),
  .irq_o       (irq_o),
  .dma_req_o   (dma_req_o),
  .wakeup_o    (wakeup_o),
  .keep_iclk_o (keep_iclk_o),
  .keep_fclk_o (keep_fclk_o),
  .pol_i       (act_pol)
);

// File: tb/test_idle_handshake_ctrl.sv
module test_idle_handshake_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        idle_req_i = 1'b0;
  logic        idle_ack_o;
  logic        core_busy_i = 1'b0;
  logic [0:0]  core_irq_i = '0;
  logic [0:0]  core_dma_i = '0;
  logic        wake_evt_i = 1'b0;
  logic [0:0]  irq_o;
  logic [0:0]  dma_req_o;
  logic        wakeup_o;
  logic        keep_iclk_o;
  logic        keep_fclk_o;

  always #2 clk_i = ~clk_i;

  idle_handshake_ctrl i_idle_handshake_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .idle_req_i(idle_req_i), .idle_ack_o(idle_ack_o),
    .core_busy_i(core_busy_i), .core_irq_i(core_irq_i), .core_dma_i(core_dma_i),
    .wake_evt_i(wake_evt_i), .irq_o(irq_o), .dma_req_o(dma_req_o), .wakeup_o(wakeup_o),
    .keep_iclk_o(keep_iclk_o), .keep_fclk_o(keep_fclk_o)
  );

  // outputs packed as {ack, irq, dma, wakeup, keep_iclk, keep_fclk}
  typedef struct {
    bit        chk;
    int        rq;
    bit [5:0]  outs;
    bit        chk_rd;
    bit [31:0] rd;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic step(input int rq, input bit [5:0] outs, input bit chk_rd = 1'b0,
                      input bit [31:0] rd = '0);
    exp_t e;
    e.chk = 1'b1; e.rq = rq; e.outs = outs; e.chk_rd = chk_rd; e.rd = rd;
    exp_q.push_back(e);
    @(posedge clk_i);
    #2;
  endtask

  task automatic wr(input bit [31:0] d);
    exp_t e;
    e.chk = 1'b0; e.rq = 0; e.outs = '0; e.chk_rd = 1'b0; e.rd = '0;
    cfg_we_i = 1'b1;
    cfg_wdata_i = d;
    exp_q.push_back(e);
    @(posedge clk_i);
    #2;
    cfg_we_i = 1'b0;
  endtask

  // monitor
  always begin
    @(posedge clk_i);
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      bit [5:0] act;
      e = exp_q.pop_front();
      act = {idle_ack_o, irq_o[0], dma_req_o[0], wakeup_o, keep_iclk_o, keep_fclk_o};
      if (e.chk) begin
        n_cmp++;
        if (act !== e.outs) begin
          n_bad++;
          $display("FAIL R%0d: outs=%b expected=%b", e.rq, act, e.outs);
        end
        if (e.chk_rd) begin
          n_cmp++;
          if (cfg_rdata_o !== e.rd) begin
            n_bad++;
            $display("FAIL R%0d: rdata=%h expected=%h", e.rq, cfg_rdata_o, e.rd);
          end
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #10 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    step(1, 6'b000011, 1'b1, 32'h0);
    // R1 only defined fields stick
    wr(32'hFFFF_FFFF);
    step(1, 6'b000011, 1'b1, 32'h0000_031C);

    // force policy, iclk kept, wakeup enable set
    wr(32'h0000_0104);
    core_irq_i = 1'b1; core_dma_i = 1'b1;
    step(10, 6'b011011);                 // R10 pass-through in run
    idle_req_i = 1'b1; wake_evt_i = 1'b1;
    step(2, 6'b100010);                  // R2 immediate ack, gated; R8 iclk only
    step(2, 6'b100010);                  // R2 wakeup held low despite enable
    idle_req_i = 1'b0;
    step(7, 6'b011011);                  // R7 back to run
    core_irq_i = 1'b0; core_dma_i = 1'b0; wake_evt_i = 1'b0;

    // never policy
    wr(32'h0000_0008);
    idle_req_i = 1'b1;
    step(3, 6'b000011);                  // R3
    core_irq_i = 1'b1;
    step(3, 6'b010011);                  // R3 keeps running, irq passes
    step(3, 6'b010011);
    idle_req_i = 1'b0; core_irq_i = 1'b0;
    step(3, 6'b000011);

    // smart policy, fclk kept, wakeup enable set
    wr(32'h0000_0214);
    core_busy_i = 1'b1; idle_req_i = 1'b1;
    step(4, 6'b000011);                  // R4 waiting
    step(4, 6'b000011);                  // R4 busy holds ack off
    core_busy_i = 1'b0;
    step(4, 6'b100001);                  // R4 ack after busy low; R8 fclk only
    wake_evt_i = 1'b1;
    step(5, 6'b100001);                  // R5 no wakeup
    core_irq_i = 1'b1;
    step(10, 6'b110001);                 // R10 irq passes in smart idle
    idle_req_i = 1'b0;
    step(7, 6'b010011);                  // R7
    core_irq_i = 1'b0; wake_evt_i = 1'b0;
    step(7, 6'b000011);

    // smart with wakeup, both clocks kept
    wr(32'h0000_031C);
    idle_req_i = 1'b1;
    step(4, 6'b000011);                  // R4 wait state even when idle core
    step(4, 6'b100011);                  // R8 both kept
    wake_evt_i = 1'b1;
    step(6, 6'b100111);                  // R6 wakeup rises
    wake_evt_i = 1'b0;
    step(6, 6'b100111);                  // R6 wakeup held
    idle_req_i = 1'b0;
    step(6, 6'b000011);                  // R6 wakeup cleared on withdraw

    // smart with wakeup but enable clear
    wr(32'h0000_0318);
    idle_req_i = 1'b1;
    step(6, 6'b000011);
    step(6, 6'b100011);
    wake_evt_i = 1'b1;
    step(6, 6'b100011);                  // R6 no wakeup without enable
    wake_evt_i = 1'b0;

    // deferred policy change
    wr(32'h0000_0008);
    step(9, 6'b100000);                  // R9 still acked; R8 keep field now 0
    step(9, 6'b100000);                  // R9
    idle_req_i = 1'b0;
    step(7, 6'b000011);
    idle_req_i = 1'b1;
    step(9, 6'b000011);                  // R9 never policy now active
    step(9, 6'b000011);
    idle_req_i = 1'b0;
    step(9, 6'b000011);

    @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule